// File: doc/BRIEF.md
# Prefetch Distance Estimator

This block keeps two running latency averages for a graph-traversal prefetcher. The first average tracks the cycles between consecutive reads of the work queue. The second tracks the cycles needed to fetch all the data for one vertex. Each average is an exponentially weighted moving average. Its weight is a power of two, so the division is a right shift. The queue average uses a weight of 8. The data average uses a weight of 16, which damps it more. Both averages are unsigned fixed point with four fractional bits.

From the two averages the block derives a look-ahead distance: offset = 1 + k·data_avg / queue_avg. Here k is a small multiplier supplied on a port, normally 2. The division runs in a restoring divider that produces one quotient bit per cycle. It starts after any sample update once both averages are valid. While the divider is working, a further request is dropped.

The block also raises a large-vertex flag whenever the data average is below the queue average. How the samples are measured, and how the offset and the flag are used, lie outside this block.

Top module: `prefetch_distance_est`

## Requirements
- R1: After synchronous reset, `offset` reads 1 and `large_vertex` reads 0.
- R2: The first sample seen by an average loads it directly as sample·16, with no blending against the reset value.
- R3: Each later queue sample updates the queue average as floor((sample·16 + 7·old) / 8).
- R4: Each later data sample updates the data average as floor((sample·16 + 15·old) / 16).
- R5: After a ratio computation completes, `offset` equals 1 + floor(k_mult·data_avg / queue_avg), where both averages are in the 4-fraction-bit form.
- R6: Until both averages have received at least one sample, `offset` stays at 1.
- R7: Once both averages are valid, `large_vertex` is 1 exactly when data_avg < queue_avg. Before that it is 0.
- R8: A ratio request that arrives while the divider is busy is dropped. `offset` then reflects the averages captured when the running division started.
- R9: A queue average of zero gives `offset` = OFF_MAX.
- R10: `offset` saturates at OFF_MAX (64 by default) and never exceeds it.
- R11: The value on `k_mult` when a division starts scales the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| k_mult | input | K_W (3) | Ratio multiplier k |
| q_valid | input | 1 | Queue-interval sample strobe |
| q_cycles | input | CNT_W (12) | Measured cycles between queue reads |
| d_valid | input | 1 | Vertex data-time sample strobe |
| d_cycles | input | CNT_W (12) | Measured cycles to fetch one vertex's data |
| offset | output | OFF_W (7) | Prefetch look-ahead distance |
| large_vertex | output | 1 | High when data time is below queue time |

## Verification
The bench first drives a queue sample alone, to show that the offset holds at 1. It then drives a matching data sample, to show that the first sample loads the average directly. Separate queue and data updates follow. Each one moves only its own average, and the quotient shows which weight applied.

Queue samples are then raised until the comparison flips, which exercises the mode flag in both directions. The multiplier is changed between two divisions. Two samples are sent three cycles apart, which tells a dropped request apart from a restarted division. A zero queue time and a tiny queue time reach the saturation value by two different routes.

// File: rtl/pde_pkg.sv
package pde_pkg;
  localparam int FRAC_BITS = 4;
endpackage

// File: rtl/pde_ewma.sv
module pde_ewma
  import pde_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int SHIFT = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  logic [CNT_W-1:0]           smp,
  output logic [CNT_W+FRAC_BITS-1:0] avg,
  output logic                       have
);
  localparam int AVG_W  = CNT_W + FRAC_BITS;
  localparam int WIDE_W = AVG_W + SHIFT + 1;

  logic [AVG_W-1:0]  smp_fx;
  logic [WIDE_W-1:0] wide;
  logic [AVG_W-1:0]  avg_next;

  assign smp_fx   = AVG_W'(smp) << FRAC_BITS;
  assign wide     = WIDE_W'(smp_fx) + (WIDE_W'(avg) << SHIFT) - WIDE_W'(avg);
  assign avg_next = AVG_W'(wide >> SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      avg  <= '0;
      have <= 1'b0;
    end else if (smp_valid) begin
      avg  <= have ? avg_next : smp_fx;
      have <= 1'b1;
    end
  end

  // R3 / R4: the blended average always lies between the old average and the new sample
  assert_avg_between_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && have) |=>
      ((avg >= $past(avg)) || (avg >= $past(smp_fx))) &&
      ((avg <= $past(avg)) || (avg <= $past(smp_fx))));

  // R2: the valid flag only comes up because of a sample
  assert_first_load_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(have) |-> ($past(smp_valid) && (avg == $past(smp_fx))));
endmodule

// File: rtl/pde_divider.sv
module pde_divider #(
  parameter int NUM_W = 19,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem;
  logic [DEN_W:0]   den_r;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   shifted;
  logic             fits;

  assign shifted = {rem[DEN_W-1:0], quo[NUM_W-1]};
  assign fits    = (shifted >= den_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      den_r <= '0;
      quo   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        rem <= fits ? (shifted - den_r) : shifted;
        quo <= {quo[NUM_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        rem   <= '0;
        den_r <= {1'b0, den};
        quo   <= num;
        cnt   <= CNT_W'(NUM_W);
        busy  <= 1'b1;
      end
    end
  end

  // R8: a request during a division leaves the captured divisor untouched
  assert_drop_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(den_r));

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
endmodule

// File: rtl/prefetch_distance_est.sv
module prefetch_distance_est
  import pde_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int K_W     = 3,
  parameter int Q_SHIFT = 3,
  parameter int D_SHIFT = 4,
  parameter int OFF_MAX = 64,
  parameter int OFF_W   = $clog2(OFF_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [K_W-1:0]   k_mult,
  input  logic             q_valid,
  input  logic [CNT_W-1:0] q_cycles,
  input  logic             d_valid,
  input  logic [CNT_W-1:0] d_cycles,
  output logic [OFF_W-1:0] offset,
  output logic             large_vertex
);
  localparam int AVG_W = CNT_W + FRAC_BITS;
  localparam int NUM_W = AVG_W + K_W;

  logic [AVG_W-1:0] q_avg, d_avg;
  logic             q_have, d_have, both_have;
  logic             req_r, div_start, div_busy, div_done;
  logic [NUM_W-1:0] div_num, div_quo;

  pde_ewma #(.CNT_W(CNT_W), .SHIFT(Q_SHIFT)) i_q_avg (
    .clk(clk), .rst(rst), .smp_valid(q_valid), .smp(q_cycles),
    .avg(q_avg), .have(q_have));

  pde_ewma #(.CNT_W(CNT_W), .SHIFT(D_SHIFT)) i_d_avg (
    .clk(clk), .rst(rst), .smp_valid(d_valid), .smp(d_cycles),
    .avg(d_avg), .have(d_have));

  assign both_have = q_have && d_have;
  assign div_num   = NUM_W'(k_mult) * NUM_W'(d_avg);
  assign div_start = req_r && !div_busy;

  pde_divider #(.NUM_W(NUM_W), .DEN_W(AVG_W)) i_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(q_avg),
    .busy(div_busy), .done(div_done), .quo(div_quo));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_r        <= 1'b0;
      offset       <= OFF_W'(1);
      large_vertex <= 1'b0;
    end else begin
      req_r <= (q_valid || d_valid) && (q_have || q_valid) && (d_have || d_valid);
      large_vertex <= both_have && (d_avg < q_avg);
      if (div_done) begin
        if (div_quo >= NUM_W'(OFF_MAX - 1)) offset <= OFF_W'(OFF_MAX);
        else                                offset <= OFF_W'(div_quo) + OFF_W'(1);
      end
    end
  end

  assert_offset_bound_R10: assert property (@(posedge clk) disable iff (rst)
    (offset >= OFF_W'(1)) && (offset <= OFF_W'(OFF_MAX)));

  assert_offset_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !both_have |-> (offset == OFF_W'(1)));

  assert_mode_valid_R7: assert property (@(posedge clk) disable iff (rst)
    large_vertex |-> $past(both_have));
endmodule

// File: tb/test_prefetch_distance_est.sv
module test_prefetch_distance_est;
  localparam int OFF_MAX = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] k_mult = 3'd2;
  logic       q_valid = 1'b0, d_valid = 1'b0;
  logic [11:0] q_cycles = '0, d_cycles = '0;
  logic [6:0] offset;
  logic       large_vertex;

  int total = 0, bad = 0;
  int qa = 0, da = 0, kk = 2;
  bit qh = 0, dh = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  prefetch_distance_est i_prefetch_distance_est (
    .clk(clk), .rst(rst), .k_mult(k_mult), .q_valid(q_valid), .q_cycles(q_cycles),
    .d_valid(d_valid), .d_cycles(d_cycles), .offset(offset), .large_vertex(large_vertex));

  function automatic int exp_off();
    int r;
    if (!(qh && dh)) return 1;
    if (qa == 0) return OFF_MAX;
    r = 1 + (kk * da) / qa;
    return (r > OFF_MAX) ? OFF_MAX : r;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    q_valid = 0; d_valid = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    qa = 0; da = 0; qh = 0; dh = 0;
  endtask

  task automatic send_q(int v);
    @(negedge clk) q_valid = 1'b1; q_cycles = 12'(v);
    @(negedge clk) q_valid = 1'b0;
    qa = qh ? (v * 16 + 7 * qa) / 8 : v * 16;
    qh = 1;
  endtask

  task automatic send_d(int v);
    @(negedge clk) d_valid = 1'b1; d_cycles = 12'(v);
    @(negedge clk) d_valid = 1'b0;
    da = dh ? (v * 16 + 15 * da) / 16 : v * 16;
    dh = 1;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 offset", offset, 1);
    check("R1 large_vertex", large_vertex, 0);
  endtask

  task automatic t_first_samples();
    send_q(10); settle();
    check("R6 offset with only queue sample", offset, 1);
    check("R7 flag with only queue sample", large_vertex, 0);
    send_d(40); settle();
    check("R2 first loads, R5 ratio", offset, exp_off()); // 1+1280/160 = 9
    check("R2 expected nine", offset, 9);
  endtask

  task automatic t_update_q();
    send_q(20); settle();  // qa=180
    check("R3 queue blend", offset, exp_off());
  endtask

  task automatic t_update_d();
    send_d(8); settle();   // da=608
    check("R4 data blend", offset, exp_off());
    check("R4 expected seven", offset, 7);
  endtask

  task automatic t_mode();
    send_q(200); settle();
    check("R7 flag low while data>=queue", large_vertex, (da < qa) ? 1 : 0);
    send_q(200); settle();
    check("R7 flag high while data<queue", large_vertex, 1);
    check("R5 ratio in large-vertex mode", offset, exp_off());
  endtask

  task automatic t_weight();
    k_mult = 3'd5; kk = 5;
    send_d(30); settle();
    check("R11 k multiplier five", offset, exp_off());
    k_mult = 3'd2; kk = 2;
  endtask

  task automatic t_drop();
    int saved;
    send_q(5);
    saved = exp_off();
    repeat (2) @(negedge clk);
    send_q(300);
    settle();
    check("R8 second request dropped", offset, saved);
    send_d(30); settle();
    check("R8 later request runs", offset, exp_off());
  endtask

  task automatic t_zero();
    do_reset();
    send_q(0); send_d(5); settle();
    check("R9 zero divisor", offset, OFF_MAX);
    check("R7 flag with zero queue", large_vertex, 0);
  endtask

  task automatic t_sat();
    do_reset();
    send_q(1); send_d(100); settle();
    check("R10 saturation", offset, OFF_MAX);
    check("R7 flag with small queue", large_vertex, 0);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_samples();
    t_update_q();
    t_update_d();
    t_mode();
    t_weight();
    t_drop();
    t_zero();
    t_sat();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule